// File: doc/BRIEF.md
# Seconds-Granular Watchdog with System Reset Pulse

This block guards a system against software that stops responding during a clock-frequency change. Software writes a four-bit time selection. A nonzero value arms the timer for that many whole seconds. The seconds come from a parameterised divider that counts clock cycles. If software does not write the selection back to zero before the time runs out, the block drives a low-going system reset pulse of fixed length. It also sets a sticky time-out status flag, so that software can tell after the reboot that the watchdog fired.

A separate revert-select bit is held here for the frequency logic. It tells that logic where to take the frequency setting from after the reboot: the hardware strap inputs, or the last value programmed. The expected use is to program the new frequency registers, enable the programmed frequency, and then write the time selection to zero to confirm that the system survived the change.

Top module: `wdog_reset_ctrl`

## Requirements
- R1: After power-on reset (`rst_n` low), `sys_rst_n` is 1, `tmo_flag` is 0, `revert_src` is 0 and the timer is disarmed.
- R2: A write of 0000 to the time selection disarms the timer. A pending count is cancelled and no reset pulse follows.
- R3: A write of a value n from 0001 to 1111 arms the timer. `sys_rst_n` goes low in the cycle that follows the clock edge exactly n × `CLKS_PER_SEC` cycles after the edge that took the write.
- R4: Once started, `sys_rst_n` stays low for exactly `PULSE_LEN` cycles and then returns to 1.
- R5: `tmo_flag` becomes 1 at the same edge at which the pulse starts. It stays 1 until a status write with data 0. A status write with data 1 has no effect. If a clear and an expiry fall in the same cycle, the flag stays set.
- R6: After firing, the timer is disarmed. No further pulse occurs until the time selection is written again.
- R7: A nonzero write while the timer is armed restarts the whole count, including the sub-second divider, from that write.
- R8: A time-selection write in the cycle the timer would expire takes precedence over the expiry. Writing 0000 cancels with no pulse. A nonzero value restarts the count.
- R9: `revert_src` holds the last value written with `revert_wr`: 0 selects the hardware-strap frequency after reboot, 1 selects the last programmed frequency. A time-out does not change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| sel_wr | input | 1 | Write strobe for the time selection |
| sel_wdata | input | 4 | Time selection: 0 off, n = n seconds |
| flag_wr | input | 1 | Write strobe for the time-out status bit |
| flag_wdata | input | 1 | Status write data; 0 clears, 1 is ignored |
| revert_wr | input | 1 | Write strobe for the revert-select bit |
| revert_wdata | input | 1 | Revert-select write data |
| sys_rst_n | output | 1 | Registered active-low system reset pulse |
| tmo_flag | output | 1 | Sticky time-out status |
| revert_src | output | 1 | Frequency source after reboot: 0 straps, 1 last programmed |

## Verification
Two events can fall in the same clock edge. A software write of the time selection can land in the very cycle the last second runs out, and a status clear can coincide with an expiry that sets the flag. The bench places a write exactly n × `CLKS_PER_SEC` − 1 cycles after the arming write, once with zero, once with a new value, and once as a status clear. It judges each case by whether a pulse appears, how long after the write it appears, and what the flag holds afterwards. A behavioural model compares all three outputs on every clock.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int unsigned WD_SEL_W = 4;

  typedef logic [WD_SEL_W-1:0] wd_sel_t;

  // a zero selection means the watchdog is switched off
  function automatic logic wd_sel_off(input wd_sel_t s);
    return s == '0;
  endfunction

  // true when the second now ending is the last one of the selection
  function automatic logic wd_last_sec(input wd_sel_t elapsed, input wd_sel_t sel);
    logic [WD_SEL_W:0] nxt;
    nxt = {1'b0, elapsed} + (WD_SEL_W+1)'(1);
    return nxt == {1'b0, sel};
  endfunction

  // counter width able to hold values 0 .. n-1
  function automatic int unsigned wd_cnt_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/wdog_tick_div.sv
module wdog_tick_div
  import wdog_pkg::*;
#(
  parameter int unsigned CLKS_PER_SEC = 33_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);

  localparam int unsigned CW = wd_cnt_w(CLKS_PER_SEC);
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_SEC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || restart || cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  assign tick = run && !restart && (cnt == LAST);

  // the divider never wanders past one second (R3)
  p_div_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // a restart always brings the divider back to zero (R7)
  p_restart_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt == '0);

endmodule

// File: rtl/wdog_sec_timer.sv
module wdog_sec_timer
  import wdog_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sel_wr,
  input  wd_sel_t sel_wdata,
  input  logic    tick,
  output logic    armed,
  output logic    expire
);

  wd_sel_t sel_q;
  wd_sel_t elapsed;

  // a write in the same cycle overrides the expiry
  assign expire = armed && tick && !sel_wr && wd_last_sec(elapsed, sel_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= '0;
      elapsed <= '0;
      armed   <= 1'b0;
    end else if (sel_wr) begin
      sel_q   <= sel_wdata;
      elapsed <= '0;
      armed   <= !wd_sel_off(sel_wdata);
    end else if (expire) begin
      elapsed <= '0;
      armed   <= 1'b0;
    end else if (armed && tick) begin
      elapsed <= elapsed + wd_sel_t'(1);
    end
  end

  p_zero_write_disarms_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && wd_sel_off(sel_wdata)) |=> !armed);

  p_nonzero_write_arms_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && !wd_sel_off(sel_wdata)) |=> (armed && elapsed == '0));

  p_elapsed_below_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (elapsed < sel_q));

  p_expire_disarms_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !armed);

endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse
  import wdog_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic sys_rst_n
);

  localparam int unsigned PW = wd_cnt_w(PULSE_LEN + 1);
  localparam logic [PW-1:0] PLEN = PW'(PULSE_LEN);

  logic [PW-1:0] pcnt;
  logic [PW-1:0] pcnt_nxt;

  always_comb begin
    if (fire) begin
      pcnt_nxt = PLEN;
    end else if (pcnt != '0) begin
      pcnt_nxt = pcnt - PW'(1);
    end else begin
      pcnt_nxt = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt      <= '0;
      sys_rst_n <= 1'b1;
    end else begin
      pcnt      <= pcnt_nxt;
      sys_rst_n <= (pcnt_nxt == '0);
    end
  end

  p_fire_drives_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !sys_rst_n);

  p_pulse_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && pcnt == PW'(1)) |=> sys_rst_n);

  p_low_only_counting_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_rst_n |-> (pcnt != '0));

endmodule

// File: rtl/wdog_reset_ctrl.sv
module wdog_reset_ctrl
  import wdog_pkg::*;
#(
  parameter int unsigned CLKS_PER_SEC = 33_000_000,
  parameter int unsigned PULSE_LEN    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_wr,
  input  logic [WD_SEL_W-1:0] sel_wdata,
  input  logic                flag_wr,
  input  logic                flag_wdata,
  input  logic                revert_wr,
  input  logic                revert_wdata,
  output logic                sys_rst_n,
  output logic                tmo_flag,
  output logic                revert_src
);

  logic armed;
  logic sec_tick;
  logic expire;

  wdog_tick_div #(.CLKS_PER_SEC(CLKS_PER_SEC)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (armed),
    .restart (sel_wr),
    .tick    (sec_tick)
  );

  wdog_sec_timer u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_wr    (sel_wr),
    .sel_wdata (sel_wdata),
    .tick      (sec_tick),
    .armed     (armed),
    .expire    (expire)
  );

  wdog_rst_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (expire),
    .sys_rst_n (sys_rst_n)
  );

  // sticky status: an expiry outranks a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmo_flag <= 1'b0;
    end else if (expire) begin
      tmo_flag <= 1'b1;
    end else if (flag_wr && !flag_wdata) begin
      tmo_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      revert_src <= 1'b0;
    end else if (revert_wr) begin
      revert_src <= revert_wdata;
    end
  end

  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> tmo_flag);

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && !(flag_wr && !flag_wdata)) |=> tmo_flag);

  p_flag_with_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_n) |-> tmo_flag);

  p_revert_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !revert_wr |=> $stable(revert_src));

  p_no_pulse_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !$fell(sys_rst_n));

endmodule

// File: tb/wdog_reset_ctrl_tb.sv
module wdog_reset_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CPS        = 10;
  localparam int PLEN       = 4;
  localparam int WD_LIMIT   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_wr = 1'b0;
  logic [3:0] sel_wdata = 4'd0;
  logic       flag_wr = 1'b0;
  logic       flag_wdata = 1'b0;
  logic       revert_wr = 1'b0;
  logic       revert_wdata = 1'b0;
  logic       sys_rst_n;
  logic       tmo_flag;
  logic       revert_src;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  bit m_armed = 0;
  int m_remain = 0;
  int m_low = 0;
  bit m_flag = 0;
  bit m_rev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_reset_ctrl #(.CLKS_PER_SEC(CPS), .PULSE_LEN(PLEN)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_wr       (sel_wr),
    .sel_wdata    (sel_wdata),
    .flag_wr      (flag_wr),
    .flag_wdata   (flag_wdata),
    .revert_wr    (revert_wr),
    .revert_wdata (revert_wdata),
    .sys_rst_n    (sys_rst_n),
    .tmo_flag     (tmo_flag),
    .revert_src   (revert_src)
  );

  always @(posedge clk) begin
    bit fire;
    fire = 0;
    if (!rst_n) begin
      m_armed = 0; m_remain = 0; m_low = 0; m_flag = 0; m_rev = 0;
    end else begin
      if (sel_wr) begin
        m_armed  = (sel_wdata != 0);
        m_remain = int'(sel_wdata) * CPS;
      end else if (m_armed) begin
        m_remain--;
        if (m_remain == 0) begin
          fire = 1;
          m_armed = 0;
        end
      end
      if (fire) m_low = PLEN;
      else if (m_low > 0) m_low--;
      if (fire) m_flag = 1;
      else if (flag_wr && !flag_wdata) m_flag = 0;
      if (revert_wr) m_rev = revert_wdata;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, "sys_rst_n", int'(sys_rst_n), (m_low == 0) ? 1 : 0);
      check(cur_req, "tmo_flag", int'(tmo_flag), int'(m_flag));
      check(cur_req, "revert_src", int'(revert_src), int'(m_rev));
    end
  end

  task automatic wr_sel(input logic [3:0] v);
    @(negedge clk); sel_wr = 1'b1; sel_wdata = v;
    @(negedge clk); sel_wr = 1'b0;
  endtask

  task automatic wr_flag(input logic v);
    @(negedge clk); flag_wr = 1'b1; flag_wdata = v;
    @(negedge clk); flag_wr = 1'b0;
  endtask

  task automatic wr_rev(input logic v);
    @(negedge clk); revert_wr = 1'b1; revert_wdata = v;
    @(negedge clk); revert_wr = 1'b0;
  endtask

  task automatic meas(output int dly, output int len);
    dly = 0;
    while (sys_rst_n && dly < 400) begin @(negedge clk); dly++; end
    len = 0;
    while (!sys_rst_n && len < 400) begin len++; @(negedge clk); end
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    int d, l;
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1", "sys_rst_n", int'(sys_rst_n), 1);
    check("R1", "tmo_flag", int'(tmo_flag), 0);
    check("R1", "revert_src", int'(revert_src), 0);
    rst_n = 1'b1;
    repeat (5 * CPS) @(negedge clk);
    check("R1", "no pulse while disarmed", int'(sys_rst_n), 1);

    cur_req = "R9";
    wr_rev(1'b1);
    check("R9", "revert after write 1", int'(revert_src), 1);
    wr_rev(1'b0);
    check("R9", "revert after write 0", int'(revert_src), 0);
    wr_rev(1'b1);

    cur_req = "R3";
    wr_sel(4'd1);
    meas(d, l);
    check("R3", "delay n=1", d, CPS);
    check("R4", "pulse length", l, PLEN);
    check("R5", "flag after expiry", int'(tmo_flag), 1);

    cur_req = "R5";
    wr_flag(1'b1);
    check("R5", "flag after write 1", int'(tmo_flag), 1);
    wr_flag(1'b0);
    check("R5", "flag after write 0", int'(tmo_flag), 0);

    cur_req = "R6";
    repeat (3 * CPS) @(negedge clk);
    check("R6", "no second pulse", int'(sys_rst_n), 1);
    check("R6", "flag stays clear", int'(tmo_flag), 0);

    cur_req = "R3";
    wr_sel(4'd3);
    meas(d, l);
    check("R3", "delay n=3", d, 3 * CPS);
    check("R4", "pulse length n=3", l, PLEN);
    wr_flag(1'b0);

    cur_req = "R2";
    wr_sel(4'd2);
    repeat (CPS) @(negedge clk);
    wr_sel(4'd0);
    repeat (4 * CPS) @(negedge clk);
    check("R2", "no pulse after cancel", int'(sys_rst_n), 1);
    check("R2", "flag after cancel", int'(tmo_flag), 0);

    cur_req = "R7";
    wr_sel(4'd2);
    repeat (14) @(negedge clk);
    wr_sel(4'd2);
    meas(d, l);
    check("R7", "delay after kick", d, 2 * CPS);
    wr_flag(1'b0);

    cur_req = "R8";
    wr_sel(4'd1);
    repeat (CPS - 2) @(negedge clk);
    wr_sel(4'd0);
    repeat (3 * CPS) @(negedge clk);
    check("R8", "zero write at expiry cancels", int'(sys_rst_n), 1);
    check("R8", "flag after cancel at expiry", int'(tmo_flag), 0);
    wr_sel(4'd1);
    repeat (CPS - 2) @(negedge clk);
    wr_sel(4'd2);
    meas(d, l);
    check("R8", "restart at expiry delay", d, 2 * CPS);
    wr_flag(1'b0);

    cur_req = "R5";
    wr_sel(4'd1);
    repeat (CPS - 2) @(negedge clk);
    @(negedge clk); flag_wr = 1'b1; flag_wdata = 1'b0;
    @(negedge clk); flag_wr = 1'b0;
    check("R5", "pulse started with clear", int'(sys_rst_n), 0);
    check("R5", "set wins over clear", int'(tmo_flag), 1);
    repeat (PLEN + 2) @(negedge clk);
    wr_flag(1'b0);

    cur_req = "R3";
    wr_sel(4'd15);
    meas(d, l);
    check("R3", "delay n=15", d, 15 * CPS);
    check("R4", "pulse length n=15", l, PLEN);

    cur_req = "R9";
    check("R9", "revert kept through timeouts", int'(revert_src), 1);
    wr_rev(1'b0);
    check("R9", "revert rewritten", int'(revert_src), 0);
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule